// File: doc/BRIEF.md
# Dock Flag and Predicate Unit

This block keeps the three condition flags of an instruction dock: two user flags, A and B, and a control flag, C. Each cycle it evaluates the 3-bit predicate of the instruction on deck against the flags and an outer-loop-nonzero input, and reports on `pred_pass` whether that instruction may execute. The surrounding dock supplies the predicate code, the loop state and one-cycle execute strobes. The counters and the data latch belong to the surrounding dock and are outside this block.

A set-flags instruction loads A and B from a 12-bit payload. That payload holds two 6-bit selection fields. Each selected literal is taken from the old flags, and the selected literals are ORed together. A move instruction can reload C. The source of the new C value depends on the `OUTPUT_DOCK` parameter and on the move's data-in and token-in bits. All flag writes take effect on the clock edge where the executing instruction's strobe is high.

All pins are plain control and status signals. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `dock_flags`

## Requirements
- R1: While `rst_n` is low and after its release, `flag_a`, `flag_b` and `flag_c` are 0.
- R2: Predicate codes 000 to 101 pass only when `olc_nonzero` is 1 and the tested flag equals bit 0 of the code. Bits [2:1] of the code select the flag: 00 selects A, 01 selects B and 10 selects C.
- R3: Predicate code 110 passes exactly when `olc_nonzero` is 1.
- R4: Predicate code 111 passes whatever the flags and `olc_nonzero` are.
- R5: When `set_flags_en` is high, the new A is computed from `flags_payload[11:6]` and the new B from `flags_payload[5:0]`. Within each field, bits 5 down to 0 select the literals A, not-A, B, not-B, C and not-C. The new value is the OR of the selected literals, taken from the flags before the edge.
- R6: A field with no bit set writes 0. Both user flags are computed from the old flags, so if each field selects the other flag, A and B swap.
- R7: A set-flags update never changes C. While `set_flags_en` is low, A and B hold whatever the payload is.
- R8: When `OUTPUT_DOCK`=0, a move (`move_en`=1) with `move_di` or `move_ti` set loads C from `sig_bit`.
- R9: When `OUTPUT_DOCK`=1, a move with `move_di` set loads C from `ship_bit`. A move with only `move_ti` set loads C from `sig_bit`.
- R10: C holds its value if `move_en` is low, or if the move has neither `move_di` nor `move_ti` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_code | input | 3 | Predicate code of the on-deck instruction |
| olc_nonzero | input | 1 | Outer loop counter is nonzero |
| pred_pass | output | 1 | Predicate condition is met |
| set_flags_en | input | 1 | A set-flags instruction executes this cycle |
| flags_payload | input | 12 | Two 6-bit literal-selection fields (A in [11:6], B in [5:0]) |
| move_en | input | 1 | A move instruction executes this cycle |
| move_di | input | 1 | Move has its data-in bit set |
| move_ti | input | 1 | Move has its token-in bit set |
| sig_bit | input | 1 | Signal bit of the incoming packet |
| ship_bit | input | 1 | Bit provided by the ship |
| flag_a | output | 1 | User flag A |
| flag_b | output | 1 | User flag B |
| flag_c | output | 1 | Control flag C |

## Verification
The bench builds two copies of the block, one with `OUTPUT_DOCK`=0 and one with `OUTPUT_DOCK`=1, and drives both from the same stimulus. With only three flags, every flag state can be combined with every predicate code and both loop states. Every one of the 64 values of each selection field can be applied from every flag state. Every combination of data-in and token-in bits can be driven with the signal and ship bits set to different values, so a C value taken from the wrong source shows up on the outputs.

// File: rtl/dock_flags_pkg.sv
package dock_flags_pkg;
  localparam int NUM_FLAGS = 3;               // index 0 = A, 1 = B, 2 = C
  localparam int NUM_USER  = 2;               // A and B are user-writable
  localparam int LIT_W     = 2 * NUM_FLAGS;   // true and complement per flag
  localparam int PAY_W     = NUM_USER * LIT_W;
  localparam int PRED_W    = 3;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
  typedef logic [LIT_W-1:0]     lit_vec_t;

  typedef enum logic [PRED_W-1:0] {
    PRED_A_LO  = 3'b000,
    PRED_A_HI  = 3'b001,
    PRED_B_LO  = 3'b010,
    PRED_B_HI  = 3'b011,
    PRED_C_LO  = 3'b100,
    PRED_C_HI  = 3'b101,
    PRED_LOOP  = 3'b110,
    PRED_ALWAYS = 3'b111
  } pred_e;

  // Literal vector, most significant first: A, ~A, B, ~B, C, ~C
  function automatic lit_vec_t make_literals(flag_vec_t f);
    lit_vec_t l;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      l[LIT_W-1-2*i] = f[i];
      l[LIT_W-2-2*i] = ~f[i];
    end
    return l;
  endfunction
endpackage

// File: rtl/dock_pred_eval.sv
module dock_pred_eval
  import dock_flags_pkg::*;
(
  input  logic [PRED_W-1:0] code,
  input  logic              loop_live,
  input  flag_vec_t         flags,
  output logic              pass
);
  logic tested;

  always_comb begin
    case (code[2:1])
      2'b00:   tested = flags[0];
      2'b01:   tested = flags[1];
      default: tested = flags[2];
    endcase
  end

  always_comb begin
    if (code == PRED_ALWAYS)     pass = 1'b1;
    else if (!loop_live)         pass = 1'b0;
    else if (code == PRED_LOOP)  pass = 1'b1;
    else                         pass = (tested == code[0]);
  end
endmodule

// File: rtl/dock_user_flag_next.sv
module dock_user_flag_next
  import dock_flags_pkg::*;
(
  input  lit_vec_t  select,
  input  flag_vec_t old_flags,
  output logic      next_val
);
  lit_vec_t lits;

  always_comb begin
    lits     = make_literals(old_flags);
    next_val = |(select & lits);
  end
endmodule

// File: rtl/dock_cflag_src.sv
module dock_cflag_src #(
  parameter bit OUTPUT_DOCK = 1'b0
) (
  input  logic move_en,
  input  logic di,
  input  logic ti,
  input  logic sig_bit,
  input  logic ship_bit,
  output logic load,
  output logic value
);
  generate
    if (OUTPUT_DOCK) begin : g_out
      always_comb begin
        load  = move_en && (di || ti);
        value = di ? ship_bit : sig_bit;
      end
    end else begin : g_in
      always_comb begin
        load  = move_en && (di || ti);
        value = sig_bit;
      end
    end
  endgenerate
endmodule

// File: rtl/dock_flags.sv
module dock_flags
  import dock_flags_pkg::*;
#(
  parameter bit OUTPUT_DOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRED_W-1:0] pred_code,
  input  logic              olc_nonzero,
  output logic              pred_pass,
  input  logic              set_flags_en,
  input  logic [PAY_W-1:0]  flags_payload,
  input  logic              move_en,
  input  logic              move_di,
  input  logic              move_ti,
  input  logic              sig_bit,
  input  logic              ship_bit,
  output logic              flag_a,
  output logic              flag_b,
  output logic              flag_c
);
  flag_vec_t           flags_q;
  logic [NUM_USER-1:0] user_next;
  logic                c_load;
  logic                c_val;

  dock_pred_eval u_pred (
    .code      (pred_code),
    .loop_live (olc_nonzero),
    .flags     (flags_q),
    .pass      (pred_pass)
  );

  // One selection field per user flag; field 0 (A) sits in the upper bits
  for (genvar gi = 0; gi < NUM_USER; gi++) begin : g_user
    dock_user_flag_next u_next (
      .select    (flags_payload[PAY_W-1-gi*LIT_W -: LIT_W]),
      .old_flags (flags_q),
      .next_val  (user_next[gi])
    );
  end

  dock_cflag_src #(.OUTPUT_DOCK(OUTPUT_DOCK)) u_csrc (
    .move_en  (move_en),
    .di       (move_di),
    .ti       (move_ti),
    .sig_bit  (sig_bit),
    .ship_bit (ship_bit),
    .load     (c_load),
    .value    (c_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (set_flags_en) flags_q[NUM_USER-1:0] <= user_next;
      if (c_load)       flags_q[2]            <= c_val;
    end
  end

  assign flag_a = flags_q[0];
  assign flag_b = flags_q[1];
  assign flag_c = flags_q[2];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!flag_a && !flag_b && !flag_c));

  assert_always_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_code == 3'b111) |-> pred_pass);

  assert_loop_zero_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!olc_nonzero && pred_code != 3'b111) |-> !pred_pass);

  assert_user_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags_en |=> (flag_a == $past(flag_a) && flag_b == $past(flag_b)));

  assert_c_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!move_en || (!move_di && !move_ti)) |=> (flag_c == $past(flag_c)));

  generate
    if (OUTPUT_DOCK) begin : g_chk_out
      assert_c_from_ship_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (move_en && move_di) |=> (flag_c == $past(ship_bit)));
    end else begin : g_chk_in
      assert_c_from_signal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (move_en && (move_di || move_ti)) |=> (flag_c == $past(sig_bit)));
    end
  endgenerate
endmodule

// File: tb/dock_flags_bench.sv
module dock_flags_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pred_code = '0;
  logic        olc_nonzero = 1'b0;
  logic        set_flags_en = 1'b0;
  logic [11:0] flags_payload = '0;
  logic        move_en = 1'b0, move_di = 1'b0, move_ti = 1'b0;
  logic        sig_bit = 1'b0, ship_bit = 1'b0;
  logic        pass_i, a_i, b_i, c_i;
  logic        pass_o, a_o, b_o, c_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dock_flags #(.OUTPUT_DOCK(1'b0)) u_dock_flags (
    .clk(clk), .rst_n(rst_n), .pred_code(pred_code), .olc_nonzero(olc_nonzero),
    .pred_pass(pass_i), .set_flags_en(set_flags_en), .flags_payload(flags_payload),
    .move_en(move_en), .move_di(move_di), .move_ti(move_ti),
    .sig_bit(sig_bit), .ship_bit(ship_bit),
    .flag_a(a_i), .flag_b(b_i), .flag_c(c_i)
  );

  dock_flags #(.OUTPUT_DOCK(1'b1)) u_dock_flags_out (
    .clk(clk), .rst_n(rst_n), .pred_code(pred_code), .olc_nonzero(olc_nonzero),
    .pred_pass(pass_o), .set_flags_en(set_flags_en), .flags_payload(flags_payload),
    .move_en(move_en), .move_di(move_di), .move_ti(move_ti),
    .sig_bit(sig_bit), .ship_bit(ship_bit),
    .flag_a(a_o), .flag_b(b_o), .flag_c(c_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    set_flags_en = 1'b0; move_en = 1'b0; move_di = 1'b0; move_ti = 1'b0;
  endtask

  // Force A, B, C to chosen values on both copies in one cycle
  task automatic put_state(input logic a, input logic b, input logic c);
    set_flags_en  = 1'b1;
    flags_payload = {(a ? 6'b110000 : 6'b0), (b ? 6'b110000 : 6'b0)};
    move_en = 1'b1; move_di = 1'b1; move_ti = 1'b0;
    sig_bit = c; ship_bit = c;
    step();
    idle_inputs();
  endtask

  function automatic logic lit_or(input logic [5:0] f, input logic a, input logic b, input logic c);
    return (f[5] & a) | (f[4] & ~a) | (f[3] & b) | (f[2] & ~b) | (f[1] & c) | (f[0] & ~c);
  endfunction

  function automatic logic pred_exp(input int code, input logic olc, input logic [2:0] abc);
    if (code == 7) return 1'b1;
    if (!olc) return 1'b0;
    if (code == 6) return 1'b1;
    return abc[code/2] == code[0];
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    // R1: reset value
    check("R1 reset in", {5'b0, c_i, b_i, a_i}, 8'h0);
    check("R1 reset out", {5'b0, c_o, b_o, a_o}, 8'h0);
    rst_n = 1'b1;
    step();
    check("R1 after release", {2'b0, c_o, b_o, a_o, c_i, b_i, a_i}, 8'h0);

    // R2 R3 R4: every flag state x every code x loop state
    for (int s = 0; s < 8; s++) begin
      put_state(s[0], s[1], s[2]);
      check("R1 state setup", {c_i, b_i, a_i}, s[2:0]);
      for (int code = 0; code < 8; code++) begin
        for (int olc = 0; olc < 2; olc++) begin
          pred_code = code[2:0]; olc_nonzero = olc[0];
          #1;
          check(code == 7 ? "R4 always" : (code == 6 ? "R3 loop" : "R2 flag test"),
                {6'b0, pass_o, pass_i},
                {6'b0, pred_exp(code, olc[0], s[2:0]), pred_exp(code, olc[0], s[2:0])});
        end
      end
    end

    // R5 R6 R7: every field value from every flag state
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 64; f++) begin
        logic [5:0] fa, fb;
        fa = f[5:0]; fb = 6'd63 - f[5:0];
        put_state(s[0], s[1], s[2]);
        set_flags_en = 1'b1; flags_payload = {fa, fb};
        sig_bit = ~s[2]; ship_bit = ~s[2];
        step();
        idle_inputs();
        check(f == 0 ? "R6 empty field" : "R5 set flags", {6'b0, b_i, a_i},
              {6'b0, lit_or(fb, s[0], s[1], s[2]), lit_or(fa, s[0], s[1], s[2])});
        check("R7 c untouched by set", {6'b0, c_o, c_i}, {6'b0, s[2], s[2]});
      end
    end

    // R6: swap uses old values
    put_state(1'b1, 1'b0, 1'b0);
    set_flags_en = 1'b1; flags_payload = {6'b001000, 6'b100000};
    step();
    idle_inputs();
    check("R6 swap", {6'b0, b_i, a_i}, 8'b10);

    // R7: payload ignored while strobe low
    put_state(1'b1, 1'b0, 1'b1);
    flags_payload = 12'h0FC;
    step(); step();
    check("R7 hold", {5'b0, c_i, b_i, a_i}, 8'b101);

    // R8 R9 R10: C source for every move bit combination
    for (int c0 = 0; c0 < 2; c0++) begin
      for (int bits = 0; bits < 4; bits++) begin
        for (int sv = 0; sv < 4; sv++) begin
          logic ei, eo;
          put_state(1'b0, 1'b0, c0[0]);
          move_en = 1'b1; move_di = bits[1]; move_ti = bits[0];
          sig_bit = sv[0]; ship_bit = sv[1];
          step();
          idle_inputs();
          ei = (bits != 0) ? sv[0] : c0[0];
          eo = bits[1] ? sv[1] : (bits[0] ? sv[0] : c0[0]);
          check(bits == 0 ? "R10 no input bits" : "R8 input dock c", {7'b0, c_i}, {7'b0, ei});
          check(bits == 0 ? "R10 no input bits" : "R9 output dock c", {7'b0, c_o}, {7'b0, eo});
        end
      end
      // R10: input bits set but no move strobe
      put_state(1'b0, 1'b0, c0[0]);
      move_en = 1'b0; move_di = 1'b1; move_ti = 1'b1;
      sig_bit = ~c0[0]; ship_bit = ~c0[0];
      step();
      idle_inputs();
      check("R10 no move", {6'b0, c_o, c_i}, {6'b0, c0[0], c0[0]});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule